// File: doc/BRIEF.md
# Parallel-Bus Converter Sequencer

This block runs one conversion on an external 16-bit converter with a parallel data bus, all in the host clock domain. When `go` is seen while it is idle, the block does the following in order:

- It lowers the chip select.
- It holds the start strobe low for a number of cycles. That count is the 20 ns minimum rounded up to whole clock periods.
- It waits for the converter's busy line to rise and then to fall. The busy line is first passed through a synchronizer.
- It reads the data bus, then presents the finished word with a one-cycle valid pulse.

Readout has two forms, chosen when the trigger is accepted:

- **Wide form:** one 16-bit read.
- **Narrow form:** two reads on the upper eight bus lanes. The lane-select output is low for the upper half of the result and high for the lower half.

Read strobes are kept out of a quiet zone around each falling edge of the start strobe. The zone covers 50 ns before that edge and 40 ns after it, converted to cycles. If busy does not rise or does not fall in time, the block abandons the conversion and sets a timeout flag. A trigger that arrives while work is under way is dropped and sets an overrun flag.

Top module: `pconv_ctl`

## Requirements
- R1: `chip_sel_n` goes low at least one cycle before `start_n` falls, and it stays low while `start_n` or `read_n` is low.
- R2: `start_n` stays low for exactly ceil(`CNV_LOW_NS`/`CLK_NS`) cycles, which is 2 cycles at the defaults.
- R3: `read_n` is high for at least ceil(`QUIET_PRE_NS`/`CLK_NS`) cycles (5 by default) before `start_n` falls. `read_n` does not fall until at least ceil(`QUIET_POST_NS`/`CLK_NS`) cycles (4 by default) after that fall.
- R4: `read_n` falls only after the synchronized busy has dropped. Each strobe is low for exactly `RD_LEN` cycles, and the bus is captured on the last low cycle.
- R5: In wide form (`narrow`=0 at acceptance), there is a single read with `lane_hi`=0, and `data_out`[15:0] = `bus_in`[15:0].
- R6: In narrow form (`narrow`=1), there are two reads and `read_n` returns high between them. In the first read `lane_hi`=0 and `data_out`[15:8] = `bus_in`[15:8]. In the second read `lane_hi`=1 and `data_out`[7:0] = `bus_in`[15:8]. `bus_in`[7:0] has no effect in this form.
- R7: `data_vld` is a one-cycle pulse. On that same edge `chip_sel_n` returns high. `data_out` holds its value until the next completion.
- R8: `narrow` is sampled only when a trigger is accepted. Changing it later does not affect the conversion in progress.
- R9: If synchronized busy fails to rise within `TO_CYC` cycles of `start_n` rising, or fails to fall within `TO_CYC` cycles of rising, the following happens:
  - `tmo_err` is set.
  - `chip_sel_n` returns high.
  - No read or valid pulse occurs.
  - The flag clears on the next accepted trigger.
- R10: A `go` that arrives while not idle is ignored and sets `ovr_flag`, and the conversion in progress completes correctly. `ovr_flag` clears on the next accepted trigger.
- R11: After reset, the following hold:
  - `chip_sel_n`, `start_n` and `read_n` are 1.
  - `lane_hi`, `data_vld`, `tmo_err` and `ovr_flag` are 0.
  - `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Conversion trigger, accepted when idle |
| narrow | input | 1 | 1 = two 8-bit reads, 0 = one 16-bit read |
| cvt_busy | input | 1 | Converter busy line, asynchronous |
| bus_in | input | 16 | Sampled converter data bus |
| chip_sel_n | output | 1 | Chip select, active low |
| start_n | output | 1 | Conversion start strobe, active low |
| read_n | output | 1 | Read strobe, active low |
| lane_hi | output | 1 | Lane select: 1 requests the lower result byte on the upper lanes |
| data_out | output | 16 | Assembled result |
| data_vld | output | 1 | One-cycle pulse marking a new result |
| tmo_err | output | 1 | Busy handshake timed out (sticky) |
| ovr_flag | output | 1 | Trigger rejected while busy (sticky) |

## Verification
Most sequencer state errors show up within one conversion as a wrong strobe shape, each visible within a few cycles of the event concerned:

- a start pulse of the wrong width;
- a read inside the quiet zone or while busy is still high;
- a missing second read, or a read with the wrong lane;
- a result word with bytes taken from the wrong lanes.

Capture errors show up in `data_out` at the valid pulse of that same conversion. Errors in the timeout or overrun logic appear at the flag pins once the timeout window ends, or on the valid pulse after the rejected trigger.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CSLOW, S_CNV, S_WHI, S_WLO, S_RSET, S_RSTB, S_RHLD
  } pcc_state_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pcc_quiet.sv
module pcc_quiet #(
  parameter int PRE_CYC  = 5,
  parameter int POST_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic read_n,
  input  logic cnv_fall,
  output logic pre_ok,
  output logic post_ok
);
  localparam int MX = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int GW = $clog2(MX + 2);

  logic [GW-1:0] rd_gap;
  logic [GW-1:0] fall_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_gap   <= GW'(PRE_CYC);
      fall_gap <= GW'(POST_CYC);
    end else begin
      if (!read_n)                    rd_gap <= '0;
      else if (rd_gap < GW'(PRE_CYC)) rd_gap <= rd_gap + 1'b1;
      if (cnv_fall)                        fall_gap <= '0;
      else if (fall_gap < GW'(POST_CYC))   fall_gap <= fall_gap + 1'b1;
    end
  end

  assign pre_ok  = (rd_gap >= GW'(PRE_CYC));
  assign post_ok = (fall_gap >= GW'(POST_CYC));
endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
  import pcc_pkg::*;
#(
  parameter int START_CYC = 2,
  parameter int PRE_CYC   = 5,
  parameter int POST_CYC  = 4,
  parameter int RD_SETUP  = 1,
  parameter int RD_LEN    = 2,
  parameter int RD_HOLD   = 1,
  parameter int TO_CYC    = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic narrow,
  input  logic busy_s,
  input  logic pre_ok,
  input  logic post_ok,
  output logic chip_sel_n,
  output logic start_n,
  output logic read_n,
  output logic lane_hi,
  output logic narrow_q,
  output logic cap,
  output logic fin,
  output logic cnv_fall,
  output logic tmo_err,
  output logic ovr_flag
);
  localparam int CW = $clog2(TO_CYC + START_CYC + RD_SETUP + RD_LEN + RD_HOLD + 2);

  pcc_state_t    state;
  logic [CW-1:0] cnt;

  assign cnv_fall = (state == S_CSLOW) && pre_ok;
  assign cap      = (state == S_RSTB) && (cnt == CW'(RD_LEN - 1));
  assign fin      = (state == S_RHLD) && (cnt == CW'(RD_HOLD - 1)) && !(narrow_q && !lane_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      chip_sel_n <= 1'b1;
      start_n    <= 1'b1;
      read_n     <= 1'b1;
      lane_hi    <= 1'b0;
      narrow_q   <= 1'b0;
      tmo_err    <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      if (go && state != S_IDLE) ovr_flag <= 1'b1;
      case (state)
        S_IDLE: if (go) begin
          state      <= S_CSLOW;
          chip_sel_n <= 1'b0;
          narrow_q   <= narrow;
          tmo_err    <= 1'b0;
          ovr_flag   <= 1'b0;
          cnt        <= '0;
        end
        S_CSLOW: if (pre_ok) begin
          state   <= S_CNV;
          start_n <= 1'b0;
          cnt     <= CW'(1);
        end
        S_CNV: if (cnt >= CW'(START_CYC)) begin
          start_n <= 1'b1;
          state   <= S_WHI;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
        S_WHI: if (busy_s) begin
          state <= S_WLO;
          cnt   <= '0;
        end else if (cnt == CW'(TO_CYC - 1)) begin
          state      <= S_IDLE;
          chip_sel_n <= 1'b1;
          tmo_err    <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_WLO: if (!busy_s) begin
          state   <= S_RSET;
          lane_hi <= 1'b0;
          cnt     <= '0;
        end else if (cnt == CW'(TO_CYC - 1)) begin
          state      <= S_IDLE;
          chip_sel_n <= 1'b1;
          tmo_err    <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_RSET: begin
          if (cnt >= CW'(RD_SETUP - 1) && post_ok) begin
            read_n <= 1'b0;
            state  <= S_RSTB;
            cnt    <= '0;
          end else if (cnt < CW'(RD_SETUP - 1)) cnt <= cnt + 1'b1;
        end
        S_RSTB: if (cnt == CW'(RD_LEN - 1)) begin
          read_n <= 1'b1;
          state  <= S_RHLD;
          cnt    <= '0;
        end else cnt <= cnt + 1'b1;
        S_RHLD: if (cnt == CW'(RD_HOLD - 1)) begin
          cnt <= '0;
          if (narrow_q && !lane_hi) begin
            lane_hi <= 1'b1;
            state   <= S_RSET;
          end else begin
            lane_hi    <= 1'b0;
            chip_sel_n <= 1'b1;
            state      <= S_IDLE;
          end
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker counters, independent of the sequencing counters above.
  logic [7:0] ck_low, ck_rdhi, ck_sfall;
  logic       ck_start_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_low <= '0; ck_rdhi <= 8'hFF; ck_sfall <= 8'hFF; ck_start_q <= 1'b1;
    end else begin
      ck_start_q <= start_n;
      ck_low     <= !start_n ? ck_low + 8'd1 : 8'd0;
      if (!read_n) ck_rdhi <= '0;
      else if (ck_rdhi != 8'hFF) ck_rdhi <= ck_rdhi + 8'd1;
      if (ck_start_q && !start_n) ck_sfall <= '0;
      else if (ck_sfall != 8'hFF) ck_sfall <= ck_sfall + 8'd1;
    end
  end

  a_r1_sel_leads_start: assert property (@(posedge clk) disable iff (rst)
    $fell(start_n) |-> $past(!chip_sel_n));
  a_r1_sel_held: assert property (@(posedge clk) disable iff (rst)
    (!start_n || !read_n) |-> !chip_sel_n);
  a_r2_start_width: assert property (@(posedge clk) disable iff (rst)
    $rose(start_n) |-> (ck_low == 8'(START_CYC)));
  a_r3_quiet_before: assert property (@(posedge clk) disable iff (rst)
    $fell(start_n) |-> (ck_rdhi >= 8'(PRE_CYC)));
  a_r3_quiet_after: assert property (@(posedge clk) disable iff (rst)
    $fell(read_n) |-> (ck_sfall >= 8'(POST_CYC)));
  a_r4_read_not_busy: assert property (@(posedge clk) disable iff (rst)
    !read_n |-> !busy_s);
  a_r6_lane_narrow_only: assert property (@(posedge clk) disable iff (rst)
    lane_hi |-> narrow_q);
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (go && state != S_IDLE) |=> ovr_flag);
endmodule

// File: rtl/pcc_assemble.sv
module pcc_assemble #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          narrow_q,
  input  logic          lane_hi,
  input  logic          fin,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] data_out,
  output logic          data_vld
);
  localparam int HW = DW / 2;

  logic [DW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      data_out <= '0;
      data_vld <= 1'b0;
    end else begin
      if (cap) begin
        if (!narrow_q)    acc          <= bus_in;
        else if (!lane_hi) acc[DW-1:HW] <= bus_in[DW-1:HW];
        else               acc[HW-1:0]  <= bus_in[DW-1:HW];
      end
      data_vld <= fin;
      if (fin) data_out <= acc;
    end
  end

  a_r7_vld_single: assert property (@(posedge clk) disable iff (rst)
    data_vld |=> !data_vld);
  a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
    !data_vld |-> $stable(data_out));
endmodule

// File: rtl/pconv_ctl.sv
module pconv_ctl
  import pcc_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int DW            = 16,
  parameter int CNV_LOW_NS    = 20,
  parameter int QUIET_PRE_NS  = 50,
  parameter int QUIET_POST_NS = 40,
  parameter int RD_SETUP      = 1,
  parameter int RD_LEN        = 2,
  parameter int RD_HOLD       = 1,
  parameter int TO_CYC        = 256,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          narrow,
  input  logic          cvt_busy,
  input  logic [DW-1:0] bus_in,
  output logic          chip_sel_n,
  output logic          start_n,
  output logic          read_n,
  output logic          lane_hi,
  output logic [DW-1:0] data_out,
  output logic          data_vld,
  output logic          tmo_err,
  output logic          ovr_flag
);
  localparam int START_CYC = ns_to_cyc(CNV_LOW_NS, CLK_NS);
  localparam int PRE_CYC   = ns_to_cyc(QUIET_PRE_NS, CLK_NS);
  localparam int POST_CYC  = ns_to_cyc(QUIET_POST_NS, CLK_NS);

  logic busy_s, pre_ok, post_ok, cnv_fall, cap, fin, narrow_q;

  pcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cvt_busy), .q(busy_s)
  );

  pcc_quiet #(.PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) u_quiet (
    .clk(clk), .rst(rst), .read_n(read_n), .cnv_fall(cnv_fall),
    .pre_ok(pre_ok), .post_ok(post_ok)
  );

  pcc_fsm #(
    .START_CYC(START_CYC), .PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC),
    .RD_SETUP(RD_SETUP), .RD_LEN(RD_LEN), .RD_HOLD(RD_HOLD), .TO_CYC(TO_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .go(go), .narrow(narrow), .busy_s(busy_s),
    .pre_ok(pre_ok), .post_ok(post_ok),
    .chip_sel_n(chip_sel_n), .start_n(start_n), .read_n(read_n),
    .lane_hi(lane_hi), .narrow_q(narrow_q), .cap(cap), .fin(fin),
    .cnv_fall(cnv_fall), .tmo_err(tmo_err), .ovr_flag(ovr_flag)
  );

  pcc_assemble #(.DW(DW)) u_asm (
    .clk(clk), .rst(rst), .cap(cap), .narrow_q(narrow_q), .lane_hi(lane_hi),
    .fin(fin), .bus_in(bus_in), .data_out(data_out), .data_vld(data_vld)
  );

  a_r9_no_read_after_timeout: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err) |-> (chip_sel_n && read_n && !data_vld));
endmodule

// File: tb/test_pconv_ctl.sv
module test_pconv_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, narrow = 1'b0, cvt_busy = 1'b0;
  logic [15:0] bus_in;
  logic chip_sel_n, start_n, read_n, lane_hi, data_vld, tmo_err, ovr_flag;
  logic [15:0] data_out;

  always #5 clk = ~clk;

  pconv_ctl i_pconv_ctl (
    .clk(clk), .rst(rst), .go(go), .narrow(narrow), .cvt_busy(cvt_busy),
    .bus_in(bus_in), .chip_sel_n(chip_sel_n), .start_n(start_n),
    .read_n(read_n), .lane_hi(lane_hi), .data_out(data_out),
    .data_vld(data_vld), .tmo_err(tmo_err), .ovr_flag(ovr_flag)
  );

  int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
  bit done = 1'b0;

  // Converter model: 0 normal, 1 never busy, 2 busy stuck high
  int mdl_mode = 0;
  logic [15:0] next_word = '0, cur = '0;
  int phase = 0, pcnt = 0;
  logic start_q = 1'b1;

  always @(posedge clk) begin
    start_q <= start_n;
    if (start_q && !start_n && !chip_sel_n && mdl_mode != 1) begin
      cur <= next_word; phase <= 1; pcnt <= 0;
    end else if (phase == 1) begin
      if (pcnt == 2) begin cvt_busy <= 1'b1; phase <= 2; pcnt <= 0; end
      else pcnt <= pcnt + 1;
    end else if (phase == 2 && mdl_mode != 2) begin
      if (pcnt == 11) begin cvt_busy <= 1'b0; phase <= 0; end
      else pcnt <= pcnt + 1;
    end
  end

  assign bus_in = (!chip_sel_n && !read_n) ? (lane_hi ? {cur[7:0], 8'hFF} : cur) : 16'hA5C3;

  // Strobe monitor
  int lowrun = 0, rdlow = 0, since_rdhi = 100, since_fall = 100;
  int rd_falls = 0, hi_falls = 0;
  logic rd_q = 1'b1, st_q = 1'b1, cs_q = 1'b1;
  always @(posedge clk) begin
    if (!rst) begin
      if (st_q && !start_n) begin
        m_chk++;
        if (cs_q) begin m_err++; $display("FAIL R1 select not low before start act=%0d exp=0", cs_q); end
        m_chk++;
        if (since_rdhi < 5) begin m_err++; $display("FAIL R3 pre-quiet act=%0d exp>=5", since_rdhi); end
        since_fall = 0;
      end else since_fall++;
      if (!st_q && start_n) begin
        m_chk++;
        if (lowrun != 2) begin m_err++; $display("FAIL R2 start width act=%0d exp=2", lowrun); end
      end
      if (rd_q && !read_n) begin
        rd_falls++; if (lane_hi) hi_falls++;
        m_chk++;
        if (since_fall < 4) begin m_err++; $display("FAIL R3 post-quiet act=%0d exp>=4", since_fall); end
        m_chk++;
        if (cvt_busy || chip_sel_n) begin m_err++; $display("FAIL R4 read while busy/deselected act=%0d exp=0", cvt_busy); end
      end
      if (!rd_q && read_n) begin
        m_chk++;
        if (rdlow != 2) begin m_err++; $display("FAIL R4 read width act=%0d exp=2", rdlow); end
      end
      lowrun = !start_n ? lowrun + 1 : 0;
      rdlow  = !read_n ? rdlow + 1 : 0;
      since_rdhi = !read_n ? 0 : since_rdhi + 1;
    end
    rd_q <= read_n; st_q <= start_n; cs_q <= chip_sel_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic do_conv(input logic m8, input logic [15:0] w, input bit flip, input bit extra);
    bit got = 1'b0;
    int f0 = rd_falls, h0 = hi_falls;
    next_word = w;
    @(negedge clk); narrow = m8; go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (flip) begin repeat (3) @(negedge clk); narrow = ~m8; end // R8
    if (extra) begin @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0; end // R10
    for (int k = 0; k < 600 && !got; k++) begin
      @(negedge clk);
      if (data_vld) got = 1'b1;
    end
    chk(got, "R7 valid pulse seen", 32'(got), 1);
    chk(data_out == w, m8 ? "R6 narrow result" : "R5 wide result", 32'(data_out), 32'(w));
    chk(chip_sel_n == 1'b1, "R7 select released with valid", 32'(chip_sel_n), 1);
    chk((rd_falls - f0) == (m8 ? 2 : 1), "R5/R6 read count", 32'(rd_falls - f0), m8 ? 2 : 1);
    chk((hi_falls - h0) == (m8 ? 1 : 0), "R6 lane select reads", 32'(hi_falls - h0), m8 ? 1 : 0);
    chk(ovr_flag == extra, "R10 overrun flag", 32'(ovr_flag), 32'(extra));
    chk(tmo_err == 1'b0, "R9 timeout clear on accept", 32'(tmo_err), 0);
    @(negedge clk);
    chk(data_vld == 1'b0, "R7 valid one cycle", 32'(data_vld), 0);
    chk(data_out == w, "R7 result held", 32'(data_out), 32'(w));
    narrow = 1'b0;
  endtask

  task automatic do_timeout(input int md);
    bit seen_vld = 1'b0, got = 1'b0;
    int f0 = rd_falls;
    mdl_mode = md;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int k = 0; k < 1500 && !got; k++) begin
      @(negedge clk);
      if (data_vld) seen_vld = 1'b1;
      if (tmo_err) got = 1'b1;
    end
    chk(got, "R9 timeout flag", 32'(got), 1);
    chk(!seen_vld, "R9 no valid on timeout", 32'(seen_vld), 0);
    chk(rd_falls == f0, "R9 no read on timeout", 32'(rd_falls - f0), 0);
    chk(chip_sel_n == 1'b1, "R9 select released", 32'(chip_sel_n), 1);
    mdl_mode = 0;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(chip_sel_n && start_n && read_n, "R11 strobes high", {29'd0, chip_sel_n, start_n, read_n}, 7);
    chk(!lane_hi && !data_vld && !tmo_err && !ovr_flag, "R11 flags low",
        {28'd0, lane_hi, data_vld, tmo_err, ovr_flag}, 0);
    chk(data_out == 16'h0, "R11 result zero", 32'(data_out), 0);

    for (int m = 0; m < 2; m++) begin
      do_conv(m[0], 16'h0000, 1'b0, 1'b0);
      do_conv(m[0], 16'hFFFF, 1'b0, 1'b0);
      do_conv(m[0], 16'h8000, 1'b0, 1'b0);
      do_conv(m[0], 16'h7FFF, 1'b0, 1'b0);
      for (int i = 0; i < 16; i++) do_conv(m[0], 16'(1) << i, 1'b0, 1'b0);
      for (int i = 0; i < 24; i++) begin
        lf = lf[0] ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
        do_conv(m[0], lf, 1'b0, 1'b0);
      end
    end
    // R8 mode change after acceptance
    do_conv(1'b0, 16'h1234, 1'b1, 1'b0);
    do_conv(1'b1, 16'h5A3C, 1'b1, 1'b0);
    // R10 overrun
    do_conv(1'b1, 16'hC3A5, 1'b0, 1'b1);
    do_conv(1'b0, 16'h0F0F, 1'b0, 1'b1);
    do_conv(1'b0, 16'h2468, 1'b0, 1'b0);
    // R9 timeouts, then a clean conversion clears the flag
    do_timeout(1);
    do_conv(1'b1, 16'h9ABC, 1'b0, 1'b0);
    do_timeout(2);
    do_conv(1'b0, 16'hDEF0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
      $finish;
    end
  end
endmodule